// File: doc/BRIEF.md
# Satellite Tuner Programming Word Sequencer

This block turns one tuning request into the four 21-bit words that program an L-band satellite tuner. A request gives a frequency in kHz and a symbol rate in symbols per second. The symbol rate picks one of three gain settings, and each setting fixes an attenuator word and a gain word. The frequency picks one of ten VCO bands, and each band fixes a one-hot band code and a VCO divider of 2 or 4. The PLL word holds the dual-modulus divider pair N/A. These come from the frequency scaled by the VCO divider and divided by a 1011 kHz comparison step. A multi-cycle restoring divider does this division.

The words leave on a valid/ready port, one at a time and always in the same order, to a serializer that shifts them into the tuner. The attenuator, gain and band words are issued while the divider is still working. The PLL word waits until the quotient is ready. A busy flag covers the whole sequence, and the block ignores start requests while busy is high.

Top module: `tuner_word_seq`

## Requirements
- R1: The attenuator word is {3'd4 in bits 20:18, 9'h007 in bits 17:9, slope in bits 8:0}. The slope is 9'h007 for rates 1,000,000..4,999,999, 9'h01F for 5,000,000..14,999,999 and 9'h03F for 15,000,000..45,000,000 (bounds inclusive).
- R2: The gain word is {3'd2 in bits 20:18, offset B in bits 17:9, offset A in bits 8:0}. In the same three rate ranges (A, B) is (9'h1F8, 9'h1F8), (9'h1E0, 9'h180) and (9'h180, 9'h100).
- R3: The band word has bits 20:10 zero, bit 9 set exactly when the VCO divider is 2, and a one-hot code in bits 8:0. The ten frequency ranges start at 950000, 1019000, 1075000, 1228000, 1350000, 1482000, 1596000, 1718000, 1856000 and 2036000 kHz, and the last one ends at 2149999 kHz. The two lowest ranges use divider 4 with codes 0x40 and 0x80. The other eight use divider 2 with codes 0x01, 0x02, 0x04 up to 0x80.
- R4: With Q = floor(floor(frequency × divider / 1011) / 2), the PLL word carries N = (Q / 32) mod 512 in bits 13:5 and A = Q mod 32 in bits 4:0. An A of 0 is sent as 1.
- R5: Bits 20:14 of the PLL word are the fixed control pattern 7'b1111110 (word value 21'h1F8000 before N and A are added).
- R6: One sequence issues exactly four words, in this order: attenuator, gain, band, PLL.
- R7: A rate outside all three rate ranges uses the lowest rate range's words. A frequency outside all ten frequency ranges uses the lowest frequency range's code (0x40) and divider 4.
- R8: While word_valid_o is high and word_ready_i is low, word_valid_o stays high and word_o keeps its value on the next cycle.
- R9: busy_o rises on the clock edge that samples start_i high while idle. It falls on the edge that accepts the fourth word. word_valid_o is never high while busy_o is low. A start_i received while busy_o is high has no effect on the words of the current sequence or on the number of words issued.
- R10: During reset and right after it, busy_o and word_valid_o are low.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new sequence (taken only when idle) |
| freq_khz_i | input | 22 | Requested frequency in kHz, sampled with start_i |
| srate_i | input | 26 | Requested symbol rate in symbols per second, sampled with start_i |
| word_ready_i | input | 1 | Downstream accepts the current word |
| word_valid_o | output | 1 | word_o holds a word to transfer |
| word_o | output | 21 | Tuner programming word |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The bench runs frequencies at both edges of the divider-4 ranges, at the change to divider 2, inside the middle bands and at the top limit. This shows whether the range comparisons are inclusive, whether the band codes are placed correctly and whether bit 9 follows the divider. Each of the three symbol-rate ranges is hit at its lower and upper bound, together with rates below and above every range, to show the fallback to the first entry. Two frequencies whose quotient is an exact multiple of 32 check that A is forced to 1, one for each divider. Downstream readiness alternates between always-ready and two stall patterns, which separates correct holding of a word from skipping or repeating it. A start issued mid-sequence with different inputs shows whether a second request leaks into the words.

// File: rtl/tws_pkg.sv
package tws_pkg;

   localparam int unsigned WORD_BITS   = 21;
   localparam int unsigned NUM_FBANDS  = 10;
   localparam int unsigned NUM_RBANDS  = 3;

   // Frequency band edges in kHz; band k covers [EDGE[k], EDGE[k+1]-1]
   localparam int unsigned FBAND_EDGE [0:10] = '{
      950000, 1019000, 1075000, 1228000, 1350000, 1482000,
      1596000, 1718000, 1856000, 2036000, 2150000
   };
   // Ranges below this index run the VCO at divide-by-4
   localparam int unsigned FBAND_DIV4_CNT = 2;

   localparam int unsigned RBAND_LO [0:2] = '{1000000, 5000000, 15000000};
   localparam int unsigned RBAND_HI [0:2] = '{4999999, 14999999, 45000000};

   localparam logic [8:0] ATT_SLOPE   [0:2] = '{9'h007, 9'h01F, 9'h03F};
   localparam logic [8:0] GAIN_OFS_A  [0:2] = '{9'h1F8, 9'h1E0, 9'h180};
   localparam logic [8:0] GAIN_OFS_B  [0:2] = '{9'h1F8, 9'h180, 9'h100};

   localparam logic [2:0]  ATT_CMD   = 3'd4;
   localparam logic [8:0]  ATT_MID   = 9'h007;
   localparam logic [2:0]  GAIN_CMD  = 3'd2;
   localparam logic [20:0] PLL_CTRL  = 21'h1F8000;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ATT,
      SQ_GAIN,
      SQ_BAND,
      SQ_PLL
   } seq_state_e;

endpackage

// File: rtl/tws_rate_sel.sv
module tws_rate_sel
   import tws_pkg::*;
#(
   parameter int unsigned RATE_W = 26
) (
   input  logic [RATE_W-1:0]    rate_i,
   output logic [WORD_BITS-1:0] att_word_o,
   output logic [WORD_BITS-1:0] gain_word_o
);

   generate
      if (RATE_W > 32) begin : g_bad_w
         $error("tws_rate_sel: RATE_W must not exceed 32");
      end
   endgenerate

   logic [31:0]           rate_ext;
   logic [NUM_RBANDS-1:0] hit;
   logic [1:0]            idx;

   assign rate_ext = 32'(rate_i);

   genvar g;
   generate
      for (g = 0; g < NUM_RBANDS; g++) begin : g_hit
         assign hit[g] = (rate_ext >= RBAND_LO[g]) && (rate_ext <= RBAND_HI[g]);
      end
   endgenerate

   // Ranges do not overlap; no hit leaves the first entry in place
   always_comb begin
      idx = 2'd0;
      for (int i = 0; i < NUM_RBANDS; i++) begin
         if (hit[i]) idx = 2'(i);
      end
   end

   assign att_word_o  = {ATT_CMD,  ATT_MID,         ATT_SLOPE[idx]};
   assign gain_word_o = {GAIN_CMD, GAIN_OFS_B[idx], GAIN_OFS_A[idx]};

endmodule

// File: rtl/tws_band_sel.sv
module tws_band_sel
   import tws_pkg::*;
#(
   parameter int unsigned FREQ_W = 22
) (
   input  logic [FREQ_W-1:0]    freq_i,
   output logic [WORD_BITS-1:0] band_word_o,
   output logic                 div4_o
);

   generate
      if (FREQ_W > 32) begin : g_bad_w
         $error("tws_band_sel: FREQ_W must not exceed 32");
      end
   endgenerate

   logic [31:0]           freq_ext;
   logic [NUM_FBANDS-1:0] hit;
   logic [3:0]            idx;
   logic [7:0]            code;

   assign freq_ext = 32'(freq_i);

   genvar g;
   generate
      for (g = 0; g < NUM_FBANDS; g++) begin : g_hit
         assign hit[g] = (freq_ext >= FBAND_EDGE[g]) && (freq_ext < FBAND_EDGE[g+1]);
      end
   endgenerate

   always_comb begin
      idx = 4'd0;
      for (int i = 0; i < NUM_FBANDS; i++) begin
         if (hit[i]) idx = 4'(i);
      end
   end

   // Divide-by-4 ranges take the two top code bits, the rest walk up from bit 0
   always_comb begin
      if (idx < 4'(FBAND_DIV4_CNT)) begin
         div4_o = 1'b1;
         code   = 8'h40 << idx;
      end else begin
         div4_o = 1'b0;
         code   = 8'h01 << (idx - 4'(FBAND_DIV4_CNT));
      end
   end

   assign band_word_o = {11'd0, ~div4_o, 1'b0, code};

endmodule

// File: rtl/tws_rdiv.sv
module tws_rdiv #(
   parameter int unsigned NUM_W = 24,
   parameter int unsigned DEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NUM_W-1:0] dividend_i,
   input  logic [DEN_W-1:0] divisor_i,
   output logic [NUM_W-1:0] quot_o,
   output logic             done_o
);

   localparam int unsigned CNT_W = $clog2(NUM_W + 1);

   generate
      if (NUM_W < 2) begin : g_bad_w
         $error("tws_rdiv: NUM_W must be at least 2");
      end
   endgenerate

   logic [NUM_W-1:0] quo_q;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [DEN_W:0]   trial;
   logic             fits;

   assign trial = {rem_q, quo_q[NUM_W-1]};
   assign fits  = trial >= {1'b0, den_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else if (start_i) begin
         quo_q  <= dividend_i;
         rem_q  <= '0;
         den_q  <= divisor_i;
         cnt_q  <= CNT_W'(NUM_W);
         run_q  <= 1'b1;
         done_o <= 1'b0;
      end else if (run_q) begin
         if (fits) begin
            rem_q <= DEN_W'(trial - {1'b0, den_q});
            quo_q <= {quo_q[NUM_W-2:0], 1'b1};
         end else begin
            rem_q <= trial[DEN_W-1:0];
            quo_q <= {quo_q[NUM_W-2:0], 1'b0};
         end
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) begin
            run_q  <= 1'b0;
            done_o <= 1'b1;
         end
      end
   end

   assign quot_o = quo_q;

endmodule

// File: rtl/tuner_word_seq.sv
module tuner_word_seq
   import tws_pkg::*;
#(
   parameter int unsigned FREQ_W    = 22,
   parameter int unsigned RATE_W    = 26,
   parameter int unsigned COMP_STEP = 1011
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [FREQ_W-1:0]    freq_khz_i,
   input  logic [RATE_W-1:0]    srate_i,
   input  logic                 word_ready_i,
   output logic                 word_valid_o,
   output logic [WORD_BITS-1:0] word_o,
   output logic                 busy_o
);

   localparam int unsigned PROD_W = FREQ_W + 2;
   localparam int unsigned DEN_W  = $clog2(COMP_STEP + 1);

   generate
      if (PROD_W < 15) begin : g_bad_prod
         $error("tuner_word_seq: FREQ_W too small for a 9-bit N field");
      end
      if (COMP_STEP < 2) begin : g_bad_step
         $error("tuner_word_seq: COMP_STEP must be at least 2");
      end
   endgenerate

   seq_state_e           state_q;
   logic [WORD_BITS-1:0] att_lut, gain_lut, band_lut;
   logic [WORD_BITS-1:0] att_q, gain_q, band_q;
   logic                 div4;
   logic                 launch;
   logic [PROD_W-1:0]    scaled_freq;
   logic [PROD_W-1:0]    quot;
   logic                 div_done;
   logic [8:0]           n_cnt;
   logic [4:0]           a_raw, a_cnt;
   logic [WORD_BITS-1:0] pll_word;
   logic                 xfer;

   tws_rate_sel #(.RATE_W(RATE_W)) u_rate (
      .rate_i      (srate_i),
      .att_word_o  (att_lut),
      .gain_word_o (gain_lut)
   );

   tws_band_sel #(.FREQ_W(FREQ_W)) u_band (
      .freq_i      (freq_khz_i),
      .band_word_o (band_lut),
      .div4_o      (div4)
   );

   assign launch      = (state_q == SQ_IDLE) && start_i;
   assign scaled_freq = div4 ? {freq_khz_i, 2'b00} : {1'b0, freq_khz_i, 1'b0};

   tws_rdiv #(.NUM_W(PROD_W), .DEN_W(DEN_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (launch),
      .dividend_i (scaled_freq),
      .divisor_i  (DEN_W'(COMP_STEP)),
      .quot_o     (quot),
      .done_o     (div_done)
   );

   // Halving drops quotient bit 0; N and A sit directly above it
   assign n_cnt    = quot[14:6];
   assign a_raw    = quot[5:1];
   assign a_cnt    = (a_raw == 5'd0) ? 5'd1 : a_raw;
   assign pll_word = PLL_CTRL | {7'd0, n_cnt, a_cnt};

   assign xfer = word_valid_o && word_ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         att_q   <= '0;
         gain_q  <= '0;
         band_q  <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (start_i) begin
               att_q   <= att_lut;
               gain_q  <= gain_lut;
               band_q  <= band_lut;
               state_q <= SQ_ATT;
            end
            SQ_ATT:  if (xfer) state_q <= SQ_GAIN;
            SQ_GAIN: if (xfer) state_q <= SQ_BAND;
            SQ_BAND: if (xfer) state_q <= SQ_PLL;
            SQ_PLL:  if (xfer) state_q <= SQ_IDLE;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      word_o       = '0;
      word_valid_o = 1'b0;
      unique case (state_q)
         SQ_ATT:  begin word_o = att_q;    word_valid_o = 1'b1;     end
         SQ_GAIN: begin word_o = gain_q;   word_valid_o = 1'b1;     end
         SQ_BAND: begin word_o = band_q;   word_valid_o = 1'b1;     end
         SQ_PLL:  begin word_o = pll_word; word_valid_o = div_done; end
         default: ;
      endcase
   end

   assign busy_o = (state_q != SQ_IDLE);

endmodule

// File: rtl/tws_seq_chk.sv
module tws_seq_chk #(
   parameter int unsigned WORD_W = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              word_ready_i,
   input logic              word_valid_o,
   input logic [WORD_W-1:0] word_o,
   input logic              busy_o
);

   logic [1:0] acc_q;
   logic       xfer;

   assign xfer = word_valid_o && word_ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n)    acc_q <= 2'd0;
      else if (xfer) acc_q <= acc_q + 2'd1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !busy_o && !word_valid_o);                               // R10

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_o)); // R8

   AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> busy_o);                                           // R9

   AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && start_i |=> busy_o);                                     // R9

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && acc_q == 2'd3 |=> !busy_o);                                 // R9

   AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> word_o[20:18] == ((acc_q == 2'd0) ? 3'd4 :
                                         (acc_q == 2'd1) ? 3'd2 :
                                         (acc_q == 2'd2) ? 3'd0 : 3'd7)); // R6

   AST_BAND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o && acc_q == 2'd2 |->
         $countones(word_o[8:0]) == 1 && word_o[20:10] == 11'd0);         // R3

   AST_PLL_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o && acc_q == 2'd3 |-> word_o[20:14] == 7'b1111110);     // R5

   AST_A_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o && acc_q == 2'd3 |-> word_o[4:0] != 5'd0);             // R4

   // start_i is observed only through the properties above
   logic unused_start;
   assign unused_start = start_i;

endmodule

bind tuner_word_seq tws_seq_chk #(.WORD_W(tws_pkg::WORD_BITS)) u_seq_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .word_ready_i (word_ready_i),
   .word_valid_o (word_valid_o),
   .word_o       (word_o),
   .busy_o       (busy_o)
);

// File: tb/tuner_word_seq_bench.sv
`timescale 1ns/1ps
module tuner_word_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [21:0] freq_khz_i = '0;
   logic [25:0] srate_i = '0;
   logic        word_ready_i = 1'b0;
   logic        word_valid_o;
   logic [20:0] word_o;
   logic        busy_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   tuner_word_seq u_tuner_word_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .freq_khz_i   (freq_khz_i),
      .srate_i      (srate_i),
      .word_ready_i (word_ready_i),
      .word_valid_o (word_valid_o),
      .word_o       (word_o),
      .busy_o       (busy_o)
   );

   // ---------------- reference model ----------------
   int    exp_q[$];
   string seq_tag = "";
   int    rdy_mode = 0;
   bit    model_busy = 0;
   int    got = 0;
   bit    hold_prev = 0;
   int    prev_word = 0;
   int    cyc = 0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, expv, $time);
      end
   endtask

   function automatic void load_expected(input int f, input int r);
      int ri, fi, dv, code, q, n, a;
      int lo [0:10] = '{950000, 1019000, 1075000, 1228000, 1350000, 1482000,
                        1596000, 1718000, 1856000, 2036000, 2150000};
      int slope [0:2] = '{'h007, 'h01F, 'h03F};
      int ofa   [0:2] = '{'h1F8, 'h1E0, 'h180};
      int ofb   [0:2] = '{'h1F8, 'h180, 'h100};
      if (r >= 1000000 && r <= 4999999)       ri = 0;
      else if (r >= 5000000 && r <= 14999999) ri = 1;
      else if (r >= 15000000 && r <= 45000000) ri = 2;
      else                                     ri = 0;
      fi = 0;
      for (int k = 0; k < 10; k++) if (f >= lo[k] && f < lo[k+1]) fi = k;
      dv   = (fi < 2) ? 4 : 2;
      code = (fi < 2) ? ('h40 << fi) : (1 << (fi - 2));
      q = ((f * dv) / 1011) / 2;
      n = (q / 32) % 512;
      a = q % 32;
      if (a == 0) a = 1;
      exp_q.delete();
      exp_q.push_back((4 << 18) | (7 << 9) | slope[ri]);
      exp_q.push_back((2 << 18) | (ofb[ri] << 9) | ofa[ri]);
      exp_q.push_back(((dv == 2) ? (1 << 9) : 0) | code);
      exp_q.push_back('h1F8000 | (n << 5) | a);
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         #1;
         cyc++;
         case (rdy_mode)
            0:       word_ready_i = 1'b1;
            1:       word_ready_i = (cyc % 3) != 0;
            default: word_ready_i = (cyc % 5) < 2;
         endcase
         if (!rst_n) begin
            check(!busy_o && !word_valid_o, "R10 reset quiet",
                  {busy_o, word_valid_o}, 0);
            model_busy = 0;
            hold_prev  = 0;
         end else begin
            bit was_busy;
            was_busy = model_busy;
            check(busy_o == model_busy, "R9 busy", busy_o, model_busy);
            if (!model_busy)
               check(!word_valid_o, "R9 valid while idle", word_valid_o, 0);
            if (hold_prev)
               check(word_valid_o && int'(word_o) == prev_word, "R8 hold",
                     int'(word_o), prev_word);
            if (model_busy && word_valid_o && word_ready_i) begin
               int e;
               string rq;
               e  = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
               rq = (got == 0) ? "R1/R6 atten" : (got == 1) ? "R2/R6 gain" :
                    (got == 2) ? "R3/R6 band" : "R4/R5/R6 pll";
               check(int'(word_o) == e, {rq, " ", seq_tag}, int'(word_o), e);
               got++;
               if (got == 4) model_busy = 0;
            end
            hold_prev = word_valid_o && !word_ready_i;
            prev_word = int'(word_o);
            if (!was_busy && start_i) begin
               load_expected(int'(freq_khz_i), int'(srate_i));
               model_busy = 1;
               got = 0;
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic run_seq(input int f, input int r, input int mode,
                          input string tag, input bit poke_busy);
      @(negedge clk);
      while (model_busy) @(negedge clk);
      rdy_mode   = mode;
      seq_tag    = tag;
      freq_khz_i = 22'(f);
      srate_i    = 26'(r);
      start_i    = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke_busy) begin
         // R9: second request while busy must not change the sequence
         repeat (2) @(negedge clk);
         freq_khz_i = 22'd2100000;
         srate_i    = 26'd20000000;
         start_i    = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      @(negedge clk);
      while (model_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0 && got == 4, {"R6 word count ", tag}, got, 4);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      run_seq(950000,  1000000,  0, "low edges", 0);
      run_seq(1018999, 4999999,  1, "div4 top", 0);
      run_seq(1019000, 5000000,  2, "band1 / rate1", 0);
      run_seq(1074999, 14999999, 0, "band1 top", 0);
      run_seq(1075000, 15000000, 1, "first div2", 0);
      run_seq(1500000, 45000000, 2, "mid band", 0);
      run_seq(2036000, 30000000, 0, "top band", 0);
      run_seq(2149999, 45000000, 1, "top edge", 0);
      run_seq(1035264, 8000000,  0, "R4 A zero div4", 0);
      run_seq(1294080, 2000000,  2, "R4 A zero div2", 0);
      run_seq(900000,  999999,   0, "R7 below ranges", 0);
      run_seq(2150000, 45000001, 1, "R7 above ranges", 0);
      run_seq(1718000, 12000000, 2, "R9 start while busy", 1);
      run_seq(1856000, 3000000,  1, "R9 start while busy b", 1);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run_seq(1400000, 27500000, 0, "after reset", 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule